// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of 32 general-purpose lines, arranged as four ports of eight pins each, behind a small 32-bit register bus with byte enables. Software sets each line's direction and drives a value onto the lines it owns as outputs. It reads back either the value it drives or the synchronized level of the pad. Each line also has an edge watcher with a 2-bit trigger field. That field both arms the line and chooses which transitions it reacts to.

A qualifying transition sets a sticky pending flag for its line. Software clears a flag by writing a 1 to it. Any pending flag raises a single registered, active-high interrupt line.

Words are packed in big-endian lane order: the first port (lines 0..7) occupies bits 31:24 and the last port (lines 24..31) occupies bits 7:0. Read data is combinational on the presented word address. Writes take effect at the clock edge where `bus_we` is high.

Each line's trigger field acts as a four-state selector:
- `TRIG_OFF` (0): disarmed.
- `TRIG_FALL` (1): reacts to 1→0 transitions.
- `TRIG_RISE` (2): reacts to 0→1 transitions.
- `TRIG_BOTH` (3): reacts to any change.

A write to the field moves the line directly from any state to any other. The new state applies from the following cycle.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every line is an input (`pin_oe` = 0), `pin_out` = 0, all trigger fields are 0, all pending flags are clear, `irq_out` = 0, and every register word reads 0.
- R2: The direction word is at byte offset 0x08. A 1 makes the line an output, a 0 an input, and `pin_oe` mirrors the stored bits. Lane mapping: line 8p+b is at word bit 8*(3-p)+b, so line 7 is bit 31 and line 24 is bit 0.
- R3: The output word is at 0x0C. Writing it sets the value driven on `pin_out`. Reading it returns, per line, the driven value for outputs and the synchronized pad level for inputs, with the same lane mapping as R2.
- R4: Pad inputs pass through two flip-flops. A pad change made between two clock edges is not visible in a read after one edge and is visible after the second.
- R5: Trigger fields are at 0x14 (ports 0 and 1) and 0x18 (ports 2 and 3). The even-numbered port of each pair uses bits 31:16, the odd-numbered port uses bits 15:0, and pin n uses bits [2n+1:2n] of its halfword. The values are 0 = off, 1 = falling, 2 = rising, 3 = both. An off or non-matching edge sets no flag.
- R6: The pending word is at 0x10, with the R2 lane mapping. A matching edge on the synchronized level sets the flag, and the flag stays set until it is cleared.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it. If an edge arrives in the same cycle as its clear, the flag ends up set.
- R8: `irq_out` is high exactly one cycle after any pending flag is set, and low one cycle after none is set.
- R9: Only bytes whose `bus_be` bit is high are written. `bus_be[3]` covers bits 31:24 and `bus_be[0]` covers bits 7:0. For trigger words, each 2-bit field follows the lane that holds it.
- R10: Offsets 0x00, 0x04 and 0x1C, and any address whose low two bits are non-zero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Byte address within the bank |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pad levels, line-indexed |
| pin_out | output | 32 | Driven values, line-indexed |
| pin_oe | output | 32 | Output enables, line-indexed |
| irq_out | output | 1 | Combined pending interrupt |

## Verification
The bench goes after the cycle where an edge and its clear collide. A design that let the clear win would silently drop that event, and the pending word would read 0 where a 1 is expected. It counts the two synchronizer stages exactly, so an extra or a missing flop shows up as a read of the data word one cycle early or late. It drives trigger fields in both halves of each word with random byte enables and random pad activity. A swapped lane, a halfword-order error or a falling/rising mix-up then makes flags appear on the wrong line or on the wrong polarity against the cycle-accurate model. Misaligned and unused offsets are written too, so a decoder that ignores the low address bits corrupts the direction or output state.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    localparam int PORTS     = 4;
    localparam int PIN_W     = 8;
    localparam int LINES     = PORTS * PIN_W;
    localparam int BUS_AW    = 5;
    localparam int IDX_W     = BUS_AW - 2;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    // word indices (byte offset / 4)
    localparam logic [IDX_W-1:0] WORD_DIR     = 3'd2;
    localparam logic [IDX_W-1:0] WORD_DATA    = 3'd3;
    localparam logic [IDX_W-1:0] WORD_STAT    = 3'd4;
    localparam logic [IDX_W-1:0] WORD_TRIG_LO = 3'd5;
    localparam logic [IDX_W-1:0] WORD_TRIG_HI = 3'd6;

    // port p lives in lane (PORTS-1-p); the map is its own inverse
    function automatic logic [LINES-1:0] lane_swap(input logic [LINES-1:0] w);
        logic [LINES-1:0] r;
        for (int p = 0; p < PORTS; p++)
            r[PIN_W*p +: PIN_W] = w[PIN_W*(PORTS-1-p) +: PIN_W];
        return r;
    endfunction

    function automatic logic [LINES-1:0] lane_mask(input logic [PORTS-1:0] be);
        logic [LINES-1:0] r;
        for (int p = 0; p < PORTS; p++)
            r[PIN_W*p +: PIN_W] = {PIN_W{be[PORTS-1-p]}};
        return r;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_unit.sv
`timescale 1ns/1ps
module gpio_edge_unit
    import gpio_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  smp,
    input  trig_e trig,
    input  logic  clr,
    output logic  flag
);
    logic prev_q;
    logic hit;
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp;
    end

    always_comb begin
        unique case (trig)
            TRIG_OFF:  hit = 1'b0;
            TRIG_FALL: hit = prev_q & ~smp;
            TRIG_RISE: hit = ~prev_q & smp;
            TRIG_BOTH: hit = prev_q ^ smp;
        endcase
    end

    // a new hit overrides a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit | (flag_q & ~clr);
    end

    assign flag = flag_q;
endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [PORTS-1:0]  bus_be,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq_out
);
    localparam int HALF = LINES / 2;

    logic [IDX_W-1:0]   idx;
    logic               aligned;
    logic               wr_ok;
    logic [LINES-1:0]   wl;
    logic [LINES-1:0]   bel;
    logic [LINES-1:0]   dir_q;
    logic [LINES-1:0]   out_q;
    logic [LINES-1:0]   sync_v;
    logic [LINES-1:0]   stat_q;
    logic [LINES-1:0]   clr_v;
    logic [2*LINES-1:0] trig_q;
    logic [LINES-1:0]   trig_lo_w;
    logic [LINES-1:0]   trig_hi_w;
    logic               irq_q;

    assign idx     = bus_addr[BUS_AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_we & aligned;
    assign wl      = lane_swap(bus_wdata);
    assign bel     = lane_mask(bus_be);

    gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (wr_ok) begin
            if (idx == WORD_DIR)  dir_q <= (dir_q & ~bel) | (wl & bel);
            if (idx == WORD_DATA) out_q <= (out_q & ~bel) | (wl & bel);
        end
    end

    assign clr_v = (wr_ok && idx == WORD_STAT) ? (wl & bel) : '0;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        localparam int PORT = l / PIN_W;
        localparam int PIN  = l % PIN_W;
        localparam int POS  = ((PORT % 2) == 0 ? HALF : 0) + 2 * PIN;
        localparam int LANE = POS / PIN_W;
        localparam logic [IDX_W-1:0] WIDX = (PORT < PORTS/2) ? WORD_TRIG_LO : WORD_TRIG_HI;

        logic [1:0] trig_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                trig_r <= 2'b00;
            else if (wr_ok && idx == WIDX && bus_be[LANE])
                trig_r <= bus_wdata[POS +: 2];
        end

        assign trig_q[2*l +: 2] = trig_r;

        if (PORT < PORTS/2) begin : g_lo
            assign trig_lo_w[POS +: 2] = trig_r;
        end else begin : g_hi
            assign trig_hi_w[POS +: 2] = trig_r;
        end

        gpio_edge_unit u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (sync_v[l]),
            .trig  (trig_e'(trig_r)),
            .clr   (clr_v[l]),
            .flag  (stat_q[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |stat_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (idx)
                WORD_DIR:     bus_rdata = lane_swap(dir_q);
                WORD_DATA:    bus_rdata = lane_swap((dir_q & out_q) | (~dir_q & sync_v));
                WORD_STAT:    bus_rdata = lane_swap(stat_q);
                WORD_TRIG_LO: bus_rdata = trig_lo_w;
                WORD_TRIG_HI: bus_rdata = trig_hi_w;
                default:      bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq_out = irq_q;
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [4:0]  bus_addr,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe,
    input logic        irq_out,
    input logic [31:0] stat_q,
    input logic [63:0] trig_q
);
    logic [31:0] armed;

    always_comb begin
        for (int l = 0; l < 32; l++) armed[l] = |trig_q[2*l +: 2];
    end

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_q) |=> irq_out);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_q) |=> !irq_out);

    // R6
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 5'h10) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R5
    stat_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(stat_q) & ~$past(armed)) == 32'h0);

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 5'h0C) |=> $stable(pin_out));

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 5'h08) |=> $stable(pin_oe));
endmodule

bind gpio_edge_bank gpio_bank_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq_out  (irq_out),
    .stat_q   (stat_q),
    .trig_q   (trig_q)
);

// File: tb/test_gpio_edge_bank.sv
`timescale 1ns/1ps
module test_gpio_edge_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_bank i_gpio_edge_bank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_dir, m_out, m_stat;
    logic [1:0]  m_mode [32];
    logic        m_irq;
    logic [31:0] hist [$];

    function automatic logic [31:0] swap_w(input logic [31:0] w);
        logic [31:0] r = '0;
        for (int l = 0; l < 32; l++) r[8*(3 - l/8) + l%8] = w[l];
        return r;
    endfunction

    function automatic logic [31:0] be_lines(input logic [3:0] be);
        logic [31:0] r = '0;
        for (int l = 0; l < 32; l++) r[l] = be[3 - l/8];
        return r;
    endfunction

    function automatic int mode_pos(input int l);
        return ((l/8) % 2 == 0 ? 16 : 0) + 2*(l%8);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_stat = '0; m_irq = 1'b0;
            for (int l = 0; l < 32; l++) m_mode[l] = 2'd0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] s, p, ev, wl, bl, clr;
            logic        ok;
            int          wi;
            s = hist[1]; p = hist[2]; ev = '0;
            for (int l = 0; l < 32; l++) begin
                case (m_mode[l])
                    2'd1: ev[l] = p[l] & ~s[l];
                    2'd2: ev[l] = ~p[l] & s[l];
                    2'd3: ev[l] = p[l] ^ s[l];
                    default: ev[l] = 1'b0;
                endcase
            end
            ok = bus_we && (bus_addr[1:0] == 2'b00);
            wi = int'(bus_addr[4:2]);
            wl = swap_w(bus_wdata);
            bl = be_lines(bus_be);
            m_irq = |m_stat;
            clr = (ok && wi == 4) ? (wl & bl) : 32'h0;
            m_stat = (m_stat & ~clr) | ev;
            if (ok && wi == 2) m_dir = (m_dir & ~bl) | (wl & bl);
            if (ok && wi == 3) m_out = (m_out & ~bl) | (wl & bl);
            if (ok && (wi == 5 || wi == 6)) begin
                for (int l = 0; l < 32; l++) begin
                    if ((l < 16) == (wi == 5) && bus_be[mode_pos(l)/8])
                        m_mode[l] = bus_wdata[mode_pos(l) +: 2];
                end
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        if (bus_addr[1:0] != 2'b00) return 32'h0;
        case (int'(bus_addr[4:2]))
            2: r = swap_w(m_dir);
            3: r = swap_w((m_dir & m_out) | (~m_dir & hist[1]));
            4: r = swap_w(m_stat);
            5, 6: for (int l = 0; l < 32; l++)
                      if ((l < 16) == (bus_addr[4:2] == 3'd5)) r[mode_pos(l) +: 2] = m_mode[l];
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    function automatic string rd_tag();
        if (bus_addr[1:0] != 2'b00) return "R10";
        case (int'(bus_addr[4:2]))
            2: return "R2";
            3: return "R3 R4";
            4: return "R6 R7";
            5, 6: return "R5 R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #1.5;
        if (rst_n && cmp_on) begin
            chk("R2 pin_oe", pin_oe, m_dir);
            chk("R3 pin_out", pin_out, m_out);
            chk("R8 irq_out", {31'h0, irq_out}, {31'h0, m_irq});
            chk(rd_tag(), bus_rdata, exp_rd());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1.5;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 8; w++) begin
            rd(5'(w*4), v);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 reset oe", pin_oe, 32'h0);
        chk("R1 reset out", pin_out, 32'h0);
        chk("R1 reset irq", {31'h0, irq_out}, 32'h0);
        cmp_on = 1'b1;

        // R2: lane mapping of direction
        wr(5'h08, 32'h8000_0001, 4'hF);
        chk("R2 dir lanes", pin_oe, 32'h0100_0080);

        // R9: only lane 2 (port 1) written
        wr(5'h08, 32'hFFFF_FFFF, 4'b0100);
        chk("R9 byte enable", pin_oe, 32'h0100_FF80);

        // R3: output drive and mixed readback
        wr(5'h0C, 32'hA500_0000, 4'b1000);
        chk("R3 pin_out", pin_out, 32'h0000_00A5);
        rd(5'h0C, v);
        chk("R3 data read", v, 32'h8000_0000);

        // R4: two-stage synchronizer latency on line 16
        @(negedge clk);
        pin_in[16] = 1'b1;
        rd(5'h0C, v);
        chk("R4 one edge", v, 32'h8000_0000);
        rd(5'h0C, v);
        chk("R4 two edges", v, 32'h8000_0100);

        // R10: unused and misaligned writes ignored
        wr(5'h00, 32'hFFFF_FFFF, 4'hF);
        rd(5'h00, v);
        chk("R10 word 0x00", v, 32'h0);
        wr(5'h09, 32'hFFFF_FFFF, 4'hF);
        chk("R10 misaligned", pin_oe, 32'h0100_FF80);

        // R7 + R8: line 0 rising, line 9 falling; edge collides with clear
        wr(5'h14, 32'h0002_0004, 4'hF);
        wr(5'h18, 32'h0, 4'hF);
        wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        idle(4);
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h0100_0000; bus_be = 4'hF;
        @(negedge clk);
        bus_we = 1'b0;
        #1.5;
        chk("R8 irq before", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        #1.5;
        chk("R8 irq after", {31'h0, irq_out}, 32'h1);
        rd(5'h10, v);
        chk("R7 set wins", v, 32'h0100_0000);
        wr(5'h10, 32'h0100_0000, 4'hF);
        rd(5'h10, v);
        chk("R7 clear", v, 32'h0);

        // R5: falling-only line ignores a rise, catches a fall
        @(negedge clk);
        pin_in[9] = 1'b1;
        idle(4);
        rd(5'h10, v);
        chk("R5 rise ignored", v, 32'h0);
        @(negedge clk);
        pin_in[9] = 1'b0;
        idle(4);
        rd(5'h10, v);
        chk("R5 fall caught", v, 32'h0002_0000);
        // R6: flag still held later
        idle(6);
        rd(5'h10, v);
        chk("R6 sticky", v, 32'h0002_0000);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            pin_in   = pin_in ^ ($urandom & $urandom & $urandom);
            bus_we   = ($urandom % 3 == 0);
            bus_addr = {3'($urandom % 8), ($urandom % 10 == 0) ? 2'($urandom % 4) : 2'b00};
            bus_be   = 4'($urandom);
            bus_wdata = $urandom;
        end
        @(negedge clk);
        bus_we = 1'b0;
        idle(4);
        cmp_on = 1'b0;
        done = 1'b1;
        finish_run();
    end
endmodule